// File: doc/BRIEF.md
# Weighted-Code Decade Up/Down Counter

This block is a chain of decimal decades that counts up and down. Each decade stores its digit in a four-bit weighted code with bit weights {2*, 4, 2, 1}. The 2* bit marks every digit of two or more. A single-cycle up request or down request, qualified by a clock enable, moves the whole chain by exactly one count. Carries and borrows ripple combinationally from the units decade upward. The chain never wraps. A count past the top or below zero leaves the value unchanged and produces a one-cycle strobe.

The outputs are the raw four-bit code of each decade, a one-of-ten decimal index per decade, and flags for all-zero and all-nines. A build parameter changes the storage to plain binary-coded decimal. The decimal behaviour is the same in both builds. The number of decades is a parameter and defaults to five.

Top module: `starcode_updown_counter`

## Requirements
- R1: While reset is asserted, and after it is released, every decade holds digit zero (code 0000), `zero_o` is 1, and `full_o`, `ovf_o` and `unf_o` are 0.
- R2: With `PLAIN_BCD`=0, the code of a decade, written {bit3,bit2,bit1,bit0}, is: 0=0000, 1=0001, 2=1000, 3=1001, 4=1010, 5=1011, 6=1100, 7=1101, 8=1110, 9=1111. Decade k occupies `code_o[4k+3:4k]`, and decade 0 is the units decade.
- R3: A clock edge with `ce_i`=1, `up_i`=1 and `dn_i`=0 raises the decimal value by one. A decade that was at 9 becomes 0 and carries into the next decade. The result appears after that edge.
- R4: A clock edge with `ce_i`=1, `dn_i`=1 and `up_i`=0 lowers the decimal value by one. A decade that was at 0 becomes 9 and borrows from the next decade.
- R5: With `ce_i`=0, up and down requests have no effect on the value.
- R6: With `ce_i`=1 and both `up_i` and `dn_i` at 1, the value holds.
- R7: An up request accepted while every decade is 9 leaves the value unchanged. `ovf_o` is then 1 for exactly the following cycle. `ovf_o` is 0 at all other times.
- R8: A down request accepted while every decade is 0 leaves the value unchanged. `unf_o` is then 1 for exactly the following cycle. `unf_o` is 0 at all other times.
- R9: `zero_o` is 1 exactly when every decade is 0. `full_o` is 1 exactly when every decade is 9.
- R10: `index_o[10k+d]` is 1 exactly when decade k holds digit d, with d from 0 to 9. Exactly one bit per decade is set.
- R11: With `PLAIN_BCD`=1, each decade stores its digit as its plain 4-bit binary value. All counting, flag and strobe behaviour is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ce_i | input | 1 | Clock enable that qualifies up and down requests |
| up_i | input | 1 | Count-up request for this cycle |
| dn_i | input | 1 | Count-down request for this cycle |
| code_o | output | 4*NUM_DIGITS | Stored code of every decade, units decade in the low nibble |
| index_o | output | 10*NUM_DIGITS | One-of-ten decimal index per decade |
| zero_o | output | 1 | Every decade is 0 |
| full_o | output | 1 | Every decade is 9 |
| ovf_o | output | 1 | Strobe: an up request was refused at the top |
| unf_o | output | 1 | Strobe: a down request was refused at zero |

## Verification
Two situations can land in the same cycle. The first is an up request and a down request arriving together. The second is a request arriving exactly at a range limit, where counting gives way to the overflow or underflow strobe.

The random phases draw `up_i` and `dn_i` independently, so coincident requests occur many times. Long directed runs push the count into both limits, then apply further and mixed requests there. Each cycle, the bench compares the stored codes, the decimal index, the flags and both strobes against a plain integer model that refuses moves past the limits.

// File: rtl/starcode_pkg.sv
package starcode_pkg;

  typedef struct packed {
    logic       ok;
    logic [3:0] val;
  } digit_t;

  // Decimal digit (0..9) to stored code
  function automatic logic [3:0] encode_digit(input logic [3:0] v, input logic plain);
    logic [3:0] t;
    if (plain || v < 4'd2) begin
      return v;
    end
    t = v - 4'd2;
    return {1'b1, t[2:0]};
  endfunction

  // Stored code to decimal digit; ok is low for a pattern no digit uses
  function automatic digit_t decode_digit(input logic [3:0] c, input logic plain);
    digit_t r;
    r.ok  = 1'b1;
    r.val = c;
    if (plain) begin
      r.ok = (c <= 4'd9);
    end else if (c[3]) begin
      r.val = {1'b0, c[2:0]} + 4'd2;
    end else if (c[2:1] != 2'b00) begin
      r.ok = 1'b0;
    end
    if (!r.ok) r.val = '0;
    return r;
  endfunction

endpackage

// File: rtl/starcode_decade_cell.sv
module starcode_decade_cell
  import starcode_pkg::*;
#(
  parameter bit PLAIN_BCD = 1'b0
) (
  input  logic [3:0] code_q,
  input  logic       inc_i,
  input  logic       dec_i,
  output logic [3:0] code_d,
  output logic       carry_o,
  output logic       borrow_o,
  output logic [3:0] val_o,
  output logic       ok_o
);

  digit_t cur;

  always_comb begin
    cur      = decode_digit(code_q, PLAIN_BCD);
    val_o    = cur.val;
    ok_o     = cur.ok;
    code_d   = code_q;
    carry_o  = 1'b0;
    borrow_o = 1'b0;
    if (!cur.ok) begin
      // a corrupted decade is cleared by any move that reaches it
      if (inc_i || dec_i) code_d = encode_digit(4'd0, PLAIN_BCD);
    end else if (inc_i) begin
      if (cur.val == 4'd9) begin
        code_d  = encode_digit(4'd0, PLAIN_BCD);
        carry_o = 1'b1;
      end else begin
        code_d = encode_digit(cur.val + 4'd1, PLAIN_BCD);
      end
    end else if (dec_i) begin
      if (cur.val == 4'd0) begin
        code_d   = encode_digit(4'd9, PLAIN_BCD);
        borrow_o = 1'b1;
      end else begin
        code_d = encode_digit(cur.val - 4'd1, PLAIN_BCD);
      end
    end
  end

endmodule

// File: rtl/starcode_digit_index.sv
module starcode_digit_index (
  input  logic [3:0] val_i,
  input  logic       ok_i,
  output logic [9:0] onehot_o
);

  always_comb begin
    for (int k = 0; k < 10; k++) begin
      onehot_o[k] = ok_i && (val_i == 4'(k));
    end
  end

endmodule

// File: rtl/starcode_updown_counter.sv
module starcode_updown_counter #(
  parameter int NUM_DIGITS = 5,
  parameter bit PLAIN_BCD  = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_i,
  input  logic                    up_i,
  input  logic                    dn_i,
  output logic [4*NUM_DIGITS-1:0] code_o,
  output logic [10*NUM_DIGITS-1:0] index_o,
  output logic                    zero_o,
  output logic                    full_o,
  output logic                    ovf_o,
  output logic                    unf_o
);

  localparam int CW = 4 * NUM_DIGITS;

  logic [1:0]            rst_pipe;
  logic                  core_rst_n;
  logic [CW-1:0]         code_q, code_d;
  logic [NUM_DIGITS:0]   carry, borrow;
  logic [NUM_DIGITS-1:0] is_zero, is_nine;
  logic                  accept, go_up, go_dn, commit;
  logic                  ovf_d, unf_d, ovf_q, unf_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  assign accept    = ce_i & (up_i ^ dn_i);
  assign go_up     = accept & up_i;
  assign go_dn     = accept & dn_i;
  assign carry[0]  = go_up;
  assign borrow[0] = go_dn;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_decade
    logic [3:0] val;
    logic       ok;

    starcode_decade_cell #(.PLAIN_BCD(PLAIN_BCD)) u_cell (
      .code_q   (code_q[4*g +: 4]),
      .inc_i    (carry[g]),
      .dec_i    (borrow[g]),
      .code_d   (code_d[4*g +: 4]),
      .carry_o  (carry[g+1]),
      .borrow_o (borrow[g+1]),
      .val_o    (val),
      .ok_o     (ok)
    );

    starcode_digit_index u_idx (
      .val_i    (val),
      .ok_i     (ok),
      .onehot_o (index_o[10*g +: 10])
    );

    assign is_zero[g] = ok && (val == 4'd0);
    assign is_nine[g] = ok && (val == 4'd9);
  end

  // a carry or borrow leaving the top decade means the move is refused
  assign ovf_d  = carry[NUM_DIGITS];
  assign unf_d  = borrow[NUM_DIGITS];
  assign commit = accept & ~ovf_d & ~unf_d;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      code_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (commit) code_q <= code_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign code_o = code_q;
  assign zero_o = &is_zero;
  assign full_o = &is_nine;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;

endmodule

// File: rtl/starcode_updown_checker.sv
module starcode_updown_checker #(
  parameter int NUM_DIGITS = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ce_i,
  input logic                     up_i,
  input logic                     dn_i,
  input logic [4*NUM_DIGITS-1:0]  code_o,
  input logic [10*NUM_DIGITS-1:0] index_o,
  input logic                     zero_o,
  input logic                     full_o,
  input logic                     ovf_o,
  input logic                     unf_o
);

  // R5
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(code_o));

  // R6
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_i && up_i && dn_i |=> $stable(code_o));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_i && up_i && !dn_i && full_o |=> ovf_o && $stable(code_o));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_i && dn_i && !up_i && zero_o |=> unf_o && $stable(code_o));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(full_o) && $past(up_i));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_o && full_o));

  // R10
  index_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(index_o) == NUM_DIGITS);

endmodule

bind starcode_updown_counter starcode_updown_checker #(.NUM_DIGITS(NUM_DIGITS)) u_chk (.*);

// File: tb/sim_starcode_updown_counter.sv
`timescale 1ns/1ps
module sim_starcode_updown_counter;
  localparam int ND   = 3;
  localparam int MAXV = 999;

  logic clk = 1'b0;
  logic rst_n, ce, up, dn;
  logic [4*ND-1:0]  code0, code1;
  logic [10*ND-1:0] idx0, idx1;
  logic zero0, full0, ovf0, unf0, zero1, full1, ovf1, unf1;

  int    tests = 0, fails = 0, model = 0;
  logic  exp_ovf = 1'b0, exp_unf = 1'b0;
  string req = "R1";

  always #2.5 clk = ~clk;

  starcode_updown_counter #(.NUM_DIGITS(ND), .PLAIN_BCD(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .up_i(up), .dn_i(dn),
    .code_o(code0), .index_o(idx0), .zero_o(zero0), .full_o(full0),
    .ovf_o(ovf0), .unf_o(unf0));

  starcode_updown_counter #(.NUM_DIGITS(ND), .PLAIN_BCD(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .up_i(up), .dn_i(dn),
    .code_o(code1), .index_o(idx1), .zero_o(zero1), .full_o(full1),
    .ovf_o(ovf1), .unf_o(unf1));

  // R2 code table
  function automatic logic [3:0] star_code(input int d);
    case (d)
      0: return 4'b0000;  1: return 4'b0001;  2: return 4'b1000;
      3: return 4'b1001;  4: return 4'b1010;  5: return 4'b1011;
      6: return 4'b1100;  7: return 4'b1101;  8: return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int digit_of(input int v, input int k);
    int p = 1;
    for (int i = 0; i < k; i++) p = p * 10;
    return (v / p) % 10;
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (model=%0d)", r, act, exp, model);
    end
  endtask

  task automatic check_all();
    logic [4*ND-1:0]  e_star, e_plain;
    logic [10*ND-1:0] e_idx;
    e_idx = '0;
    for (int k = 0; k < ND; k++) begin
      e_star[4*k +: 4]  = star_code(digit_of(model, k));
      e_plain[4*k +: 4] = 4'(digit_of(model, k));
      e_idx[10*k + digit_of(model, k)] = 1'b1;
    end
    chk({req, "/R2 star code"}, 64'(code0), 64'(e_star));
    chk({req, "/R11 plain code"}, 64'(code1), 64'(e_plain));
    chk("R10 index", 64'(idx0), 64'(e_idx));
    chk("R11 plain index", 64'(idx1), 64'(e_idx));
    chk("R9 zero flag", 64'({zero0, zero1}), 64'({2{model == 0}}));
    chk("R9 full flag", 64'({full0, full1}), 64'({2{model == MAXV}}));
    chk("R7 ovf strobe", 64'({ovf0, ovf1}), 64'({2{exp_ovf}}));
    chk("R8 unf strobe", 64'({unf0, unf1}), 64'({2{exp_unf}}));
  endtask

  // called at a falling edge; drives, then checks at the next falling edge
  task automatic step(input logic c, input logic u, input logic d);
    ce = c; up = u; dn = d;
    exp_ovf = 1'b0;
    exp_unf = 1'b0;
    if (c && (u != d)) begin
      if (u) begin
        if (model == MAXV) exp_ovf = 1'b1;
        else               model++;
      end else begin
        if (model == 0) exp_unf = 1'b1;
        else            model--;
      end
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      step(($urandom % 8) != 0, ($urandom % 10) < 6, ($urandom % 10) < 4);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1966));
    rst_n = 1'b1; ce = 1'b0; up = 1'b0; dn = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    req = "R1";
    check_all();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all();

    req = "R3"; repeat (25) step(1, 1, 0);
    req = "R6"; repeat (6) step(1, 1, 1);
    req = "R5"; repeat (4) step(0, 1, 0); repeat (4) step(0, 0, 1);
    req = "R4"; repeat (25) step(1, 0, 1);
    req = "R8"; repeat (3) step(1, 0, 1); step(1, 1, 1); step(0, 0, 1);
    req = "R3"; random_run(1500);
    req = "R7"; repeat (1100) step(1, 1, 0);
    step(1, 1, 1); step(0, 1, 0); step(1, 1, 0);
    req = "R4"; step(1, 0, 1); step(1, 0, 1);
    req = "R6"; random_run(600);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule